// File: doc/BRIEF.md
# Flagless Phase Compensation FIFO

This block carries parallel data words from a per-channel receive clock into a shared global clock, for one receive channel. The two clocks run at the same frequency and differ only by an unknown, fixed phase. The buffer has four slots. Each write-clock cycle stores one word and each read-clock cycle takes one out. There are no full or empty flags and no enables. The write pointer and the read pointer both run freely.

Each side has its own reset input. That reset is asserted at once and released through a synchronizer in its own clock domain. When reset is released, the write side begins at slot 0 and the read side begins at slot 2. This leaves about two words of margin before the pointers could meet from either direction. Storage is cleared by reset, so the registered output reads zero until the first real word reaches the read side. One instance is placed per receive channel, and all instances read on the common global clock.

Top module: `phase_comp_fifo`

## Requirements
- R1: `rd_data` is all zeros while `rd_rst_n` is low, and stays zero after release until the first word written after reset is read.
- R2: After write reset release, the word on `wr_data` is stored on every `wr_clk` rising edge. The store goes into the slot named by a 2-bit write pointer, which advances by one modulo 4 on each edge, with no enable.
- R3: After read reset release, a 2-bit read pointer advances by one modulo 4 on every `rd_clk` rising edge. `rd_data` is a register loaded from the slot that pointer names.
- R4: At release the write pointer starts at slot 0 and the read pointer at slot 2. The first nonzero output therefore appears no later than SYNC_STAGES+6 read cycles after the resets are released together.
- R5: With equal clock frequencies and any fixed phase offset, the nonzero output words follow the input words in order, with none dropped or repeated.
- R6: All DATA_W bits of a word reach `rd_data` unchanged.
- R7: Each reset input takes effect at once and is released through a chain of SYNC_STAGES flops clocked by its own domain. The output therefore stays zero for at least SYNC_STAGES+2 read cycles after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Per-channel parallel clock; performs the writes |
| wr_rst_n | input | 1 | Write-domain reset, active low, asynchronous assert |
| wr_data | input | DATA_W | Word stored on each write clock |
| rd_clk | input | 1 | Global clock; performs the reads |
| rd_rst_n | input | 1 | Read-domain reset, active low, asynchronous assert |
| rd_data | output | DATA_W | Registered output word |

## Verification
The read clock is swept over ten phase offsets against the write clock, in half-nanosecond steps across the whole period. This covers edges that coincide, edges that lead by a little, and edges that lag by a little. Each offset moves the write and read edges against each other, so a wrong start separation or a skipped pointer step shows up as a dropped or repeated word at some offset. The input words carry a counter in the low byte and a scrambled copy of it in the high byte. A continuity break shows up in one byte and a corrupted bit lane in the other. The count of leading zero words after each release shows whether the synchronizer depth and the starting slots are right.

// File: rtl/pcf_pkg.sv
`timescale 1ns/1ps
package pcf_pkg;
   // Fixed buffer depth; the frequency-locked scheme is built for four slots.
   localparam int unsigned PCF_DEPTH = 4;
   localparam int unsigned PCF_PTR_W = $clog2(PCF_DEPTH);

   typedef logic [PCF_PTR_W-1:0] pcf_ptr_t;

   // Write starts at slot 0, read starts half the depth away.
   localparam pcf_ptr_t PCF_WR_START = pcf_ptr_t'(0);
   localparam pcf_ptr_t PCF_RD_START = pcf_ptr_t'(PCF_DEPTH / 2);

   function automatic pcf_ptr_t pcf_step(input pcf_ptr_t p);
      return p + pcf_ptr_t'(1);
   endfunction
endpackage

// File: rtl/pcf_rst_sync.sv
`timescale 1ns/1ps
module pcf_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic srst_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pcf_rst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], 1'b1};
   end

   assign srst_n = chain[STAGES-1];

   // R7: the synchronized reset only rises after the raw input was high
   a_r7_release_after_input: assert property (
      @(posedge clk) disable iff (!arst_n)
      $rose(srst_n) |-> $past(arst_n));
endmodule

// File: rtl/pcf_wr_side.sv
`timescale 1ns/1ps
module pcf_wr_side
   import pcf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [DATA_W-1:0]                   din,
   output logic [PCF_DEPTH-1:0][DATA_W-1:0]    slots
);
   pcf_ptr_t wp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wp <= PCF_WR_START;
      else        wp <= pcf_step(wp);
   end

   for (genvar s = 0; s < PCF_DEPTH; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      slots[s] <= '0;
         else if (wp == pcf_ptr_t'(s))    slots[s] <= din;
      end
   end

   // R2: pointer moves by exactly one slot per write clock
   a_r2_wr_step: assert property (
      @(posedge clk) disable iff (!rst_n)
      1'b1 |=> wp == pcf_ptr_t'($past(wp) + pcf_ptr_t'(1)));

   // R2: the slot addressed last cycle now holds last cycle's input
   a_r2_slot_load: assert property (
      @(posedge clk) disable iff (!rst_n)
      1'b1 |=> slots[$past(wp)] == $past(din));
endmodule

// File: rtl/pcf_rd_side.sv
`timescale 1ns/1ps
module pcf_rd_side
   import pcf_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [PCF_DEPTH-1:0][DATA_W-1:0]    slots,
   output logic [DATA_W-1:0]                   dout
);
   pcf_ptr_t rp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp   <= PCF_RD_START;
         dout <= '0;
      end else begin
         rp   <= pcf_step(rp);
         dout <= slots[rp];
      end
   end

   // R3: read pointer moves by exactly one slot per read clock
   a_r3_rd_step: assert property (
      @(posedge clk) disable iff (!rst_n)
      1'b1 |=> rp == pcf_ptr_t'($past(rp) + pcf_ptr_t'(1)));
endmodule

// File: rtl/phase_comp_fifo.sv
`timescale 1ns/1ps
module phase_comp_fifo
   import pcf_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              wr_clk,
   input  logic              wr_rst_n,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   input  logic              rd_rst_n,
   output logic [DATA_W-1:0] rd_data
);
   if (DATA_W < 1) begin : g_bad_width
      $error("phase_comp_fifo: DATA_W must be at least 1");
   end
   if (PCF_DEPTH != 4) begin : g_bad_depth
      $error("phase_comp_fifo: only a four-slot buffer is supported");
   end

   logic wr_srst_n;
   logic rd_srst_n;
   logic [PCF_DEPTH-1:0][DATA_W-1:0] slots;

   pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_wr_rst (
      .clk    (wr_clk),
      .arst_n (wr_rst_n),
      .srst_n (wr_srst_n)
   );

   pcf_rst_sync #(.STAGES(SYNC_STAGES)) u_rd_rst (
      .clk    (rd_clk),
      .arst_n (rd_rst_n),
      .srst_n (rd_srst_n)
   );

   pcf_wr_side #(.DATA_W(DATA_W)) u_wr (
      .clk   (wr_clk),
      .rst_n (wr_srst_n),
      .din   (wr_data),
      .slots (slots)
   );

   pcf_rd_side #(.DATA_W(DATA_W)) u_rd (
      .clk   (rd_clk),
      .rst_n (rd_srst_n),
      .slots (slots),
      .dout  (rd_data)
   );
endmodule

// File: tb/phase_comp_fifo_test.sv
`timescale 1ns/1ps
module phase_comp_fifo_test;
   localparam int DW = 16;
   localparam int SS = 2;

   logic          wr_clk   = 1'b0;
   logic          rd_clk   = 1'b0;
   logic          wr_rst_n = 1'b0;
   logic          rd_rst_n = 1'b0;
   logic [DW-1:0] wr_data;
   logic [DW-1:0] rd_data;
   realtime       phase    = 0.0;
   logic [7:0]    cnt      = 8'd1;
   int            checks   = 0;
   int            errors   = 0;

   // 200 MHz write clock; read clock is a delayed copy
   always #2.5 wr_clk = ~wr_clk;
   always @(wr_clk) rd_clk <= #(phase) wr_clk;

   // Input words change away from write edges
   always @(negedge wr_clk) cnt <= (cnt == 8'hFF) ? 8'd1 : cnt + 8'd1;
   assign wr_data = {cnt ^ 8'h5A, cnt};

   phase_comp_fifo #(.DATA_W(DW), .SYNC_STAGES(SS)) uut (
      .wr_clk   (wr_clk),
      .wr_rst_n (wr_rst_n),
      .wr_data  (wr_data),
      .rd_clk   (rd_clk),
      .rd_rst_n (rd_rst_n),
      .rd_data  (rd_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   initial begin : watchdog
      #1ms;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      for (int p = 0; p < 10; p++) begin
         int         zeros;
         bit         got;
         logic [7:0] prev;
         wr_rst_n = 1'b0;
         rd_rst_n = 1'b0;
         phase    = p * 0.5;
         repeat (5) @(negedge rd_clk);
         // R1: zero output during reset
         check(rd_data == '0, "R1", "output in reset", int'(rd_data), 0);
         @(negedge wr_clk);
         #0.25;
         wr_rst_n = 1'b1;
         rd_rst_n = 1'b1;
         zeros = 0;
         got   = 1'b0;
         prev  = 8'd0;
         for (int i = 0; i < 80; i++) begin
            @(negedge rd_clk);
            if (!got) begin
               if (rd_data == '0) zeros++;
               else begin
                  got  = 1'b1;
                  prev = rd_data[7:0];
                  check(rd_data[15:8] == (rd_data[7:0] ^ 8'h5A), "R6",
                        "upper byte", int'(rd_data[15:8]),
                        int'(rd_data[7:0] ^ 8'h5A));
                  // R7 R1: zeros held through synchronizer and slots 2,3
                  check(zeros >= SS + 2, "R7", "leading zeros min", zeros, SS + 2);
                  // R4: start separation bounds first-word arrival
                  check(zeros <= SS + 6, "R4", "leading zeros max", zeros, SS + 6);
               end
            end else begin
               logic [7:0] want;
               want = (prev == 8'hFF) ? 8'd1 : prev + 8'd1;
               check(rd_data[15:8] == (rd_data[7:0] ^ 8'h5A), "R6",
                     "upper byte", int'(rd_data[15:8]),
                     int'(rd_data[7:0] ^ 8'h5A));
               // R5 (R2,R3): next word in order, no drop, no repeat
               check(rd_data[7:0] == want, "R5", "sequence", int'(rd_data[7:0]),
                     int'(want));
               prev = rd_data[7:0];
            end
         end
         check(got, "R5", "word arrived", int'(got), 1);
      end
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule